// File: doc/BRIEF.md
# Serial Port Status Flag Controller

This block keeps the four status flags of an asynchronous serial port and turns them into interrupt requests. It sits between the CPU register bus and the transmit and receive datapaths. It sees bus strobes for reads of the status register and reads or writes of the data register. From the transmitter it takes a strobe meaning "the shift register was loaded", a strobe meaning "a data, preamble or break frame was queued", and a busy level. From the receiver it takes a strobe meaning "a character was moved into the data register", a per-bit-time sample strobe with the line level, and the receiver enable.

Software clears a flag in two steps. First it reads the status register while the flag is set, which arms that flag. Then it makes the matching data-register access, which clears the flag. A data access that was not preceded by an arming read changes nothing. Line-idle detection counts consecutive high bit samples. It is allowed to fire only after a character has been received since the receiver was enabled, and again since the last time the idle flag was cleared.

Top module: `uart_flag_unit`

## Requirements
- R1: After reset, txEmpty=1, txComplete=1, rxFull=0 and rxIdle=0. No request is raised while all enables are 0.
- R2: A txLoad pulse sets txEmpty in the next cycle.
- R3: txEmpty clears only when a dataWr follows a statusRd that was made while txEmpty=1. A dataWr with no such read leaves txEmpty unchanged. A statusRd made while txEmpty=0 does not arm the flag.
- R4: txComplete is 1 exactly when txEmpty=1, txBusy=0 and no queued frame is pending. A txQueue pulse makes txComplete 0 from the next cycle. It stays 0 until txBusy has been seen high and has then returned low.
- R5: A rxXfer pulse sets rxFull in the next cycle. rxFull clears only when a dataRd follows a statusRd made while rxFull=1. A dataRd with no such read leaves rxFull unchanged.
- R6: rxIdle sets after a run of consecutive bitTick samples with rxLine=1. The run must be 10 samples long when nineBit=0 and 11 when nineBit=1. A sample with rxLine=0 restarts the count.
- R7: rxIdle cannot set until a rxXfer has occurred since the receiver was enabled, and again since rxIdle was last cleared.
- R8: rxIdle clears when a dataRd follows a statusRd made while rxIdle=1.
- R9: If a set event (txLoad or rxXfer) falls in the same cycle as the completing clear access for its flag, the flag stays 1.
- R10: While rxEn=0 the ones count is held at zero and the idle qualification from an earlier character is dropped.
- R11: txIrq = txComplete AND txDoneIe. rxIrq = rxFull AND rxFullIe. errIrq = rxIdle AND idleIe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| statusRd | input | 1 | Status register read strobe |
| dataRd | input | 1 | Data register read strobe |
| dataWr | input | 1 | Data register write strobe |
| txDoneIe | input | 1 | Transmit-complete interrupt enable |
| rxFullIe | input | 1 | Receive-full interrupt enable |
| idleIe | input | 1 | Idle interrupt enable |
| txLoad | input | 1 | Data register moved into the transmit shifter |
| txQueue | input | 1 | Data, preamble or break frame queued |
| txBusy | input | 1 | Transmitter sending a frame |
| rxXfer | input | 1 | Received character moved into the data register |
| rxEn | input | 1 | Receiver enable |
| bitTick | input | 1 | Receiver bit-time sample strobe |
| rxLine | input | 1 | Receiver input level at the sample |
| nineBit | input | 1 | 1 = 9-bit characters, 0 = 8-bit |
| txEmpty | output | 1 | Transmit data register empty flag |
| txComplete | output | 1 | Transmission complete flag |
| rxFull | output | 1 | Receive data register full flag |
| rxIdle | output | 1 | Receiver line idle flag |
| txIrq | output | 1 | Transmitter interrupt request |
| rxIrq | output | 1 | Receiver interrupt request |
| errIrq | output | 1 | Error (idle) interrupt request |

## Verification
Two functions can meet in one cycle: the set event of a flag and the data access that completes its clear sequence. The bench provokes this by making an arming status read and then pulsing the data access in the same cycle as txLoad, or in the same cycle as rxXfer. It judges the result by requiring the flag to read 1 in the following cycle. It then repeats the clear sequence alone to show that the arming was consumed correctly. The idle counter is swept over run lengths on both sides of both thresholds, and the enable combinations of all three requests are swept against known flag states.

// File: rtl/uart_flag_pkg.sv
`timescale 1ns/1ps
package uart_flag_pkg;

  // Per-cycle set and clear commands from control to the flag registers.
  typedef struct packed {
    logic setTe;
    logic clrTe;
    logic setRf;
    logic clrRf;
    logic setIdle;
    logic clrIdle;
  } flagStrobes_t;

endpackage

// File: rtl/uart_flag_ctrl.sv
`timescale 1ns/1ps
module uart_flag_ctrl
  import uart_flag_pkg::*;
#(
  parameter int CHAR_BITS = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         statusRd,
  input  logic         dataRd,
  input  logic         dataWr,
  input  logic         txLoad,
  input  logic         rxXfer,
  input  logic         rxEn,
  input  logic         bitTick,
  input  logic         rxLine,
  input  logic         nineBit,
  input  logic         txEmpty,
  input  logic         rxFull,
  input  logic         rxIdle,
  output flagStrobes_t strobe
);

  localparam int BASE_THRESH = CHAR_BITS + 2;
  localparam int CNT_W       = $clog2(BASE_THRESH + 2);

  logic             armTe, armRf, armIdle;
  logic             idleQual;
  logic [CNT_W-1:0] onesCnt;
  logic [CNT_W-1:0] thresh;
  logic             clrTe, clrRf, clrIdle, setIdle;

  assign thresh = CNT_W'(BASE_THRESH) + CNT_W'(nineBit);

  // The clear takes effect only when the data access finds the flag armed.
  assign clrTe   = dataWr & armTe;
  assign clrRf   = dataRd & armRf;
  assign clrIdle = dataRd & armIdle;
  assign setIdle = rxEn & idleQual & bitTick & rxLine & (onesCnt == thresh - CNT_W'(1));

  always_comb begin
    strobe         = '0;
    strobe.setTe   = txLoad;
    strobe.clrTe   = clrTe;
    strobe.setRf   = rxXfer;
    strobe.clrRf   = clrRf;
    strobe.setIdle = setIdle;
    strobe.clrIdle = clrIdle;
  end

  // Arming bits: a status read copies the current flag value; the matching
  // data access consumes the arming.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armTe   <= 1'b0;
      armRf   <= 1'b0;
      armIdle <= 1'b0;
    end else begin
      if (statusRd)    armTe <= txEmpty;
      else if (dataWr) armTe <= 1'b0;
      if (statusRd)    armRf <= rxFull;
      else if (dataRd) armRf <= 1'b0;
      if (statusRd)    armIdle <= rxIdle;
      else if (dataRd) armIdle <= 1'b0;
    end
  end

  // Consecutive-ones counter, saturating at the threshold.
  always_ff @(posedge clk) begin
    if (!rstN || !rxEn) begin
      onesCnt <= '0;
    end else if (bitTick) begin
      if (!rxLine)               onesCnt <= '0;
      else if (onesCnt < thresh) onesCnt <= onesCnt + CNT_W'(1);
    end
  end

  // Idle qualification: needs a received character after enable or after a clear.
  always_ff @(posedge clk) begin
    if (!rstN || !rxEn)            idleQual <= 1'b0;
    else if (rxXfer)               idleQual <= 1'b1;
    else if (clrIdle && !setIdle)  idleQual <= 1'b0;
  end

  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    onesCnt <= CNT_W'(BASE_THRESH + 1));

  a_r10_cnt_held: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> (onesCnt == '0));

  a_r3_clear_after_read: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrTe |-> $past(statusRd || armTe));

endmodule

// File: rtl/uart_flag_regs.sv
`timescale 1ns/1ps
module uart_flag_regs
  import uart_flag_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  flagStrobes_t strobe,
  input  logic         txQueue,
  input  logic         txBusy,
  input  logic         txDoneIe,
  input  logic         rxFullIe,
  input  logic         idleIe,
  output logic         txEmpty,
  output logic         txComplete,
  output logic         rxFull,
  output logic         rxIdle,
  output logic         txIrq,
  output logic         rxIrq,
  output logic         errIrq
);

  logic teQ, rfQ, idleQ, queuePend;

  // In every flag register, a set in the same cycle as a clear wins.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      teQ       <= 1'b1;
      rfQ       <= 1'b0;
      idleQ     <= 1'b0;
      queuePend <= 1'b0;
    end else begin
      if (strobe.setTe)        teQ <= 1'b1;
      else if (strobe.clrTe)   teQ <= 1'b0;
      if (strobe.setRf)        rfQ <= 1'b1;
      else if (strobe.clrRf)   rfQ <= 1'b0;
      if (strobe.setIdle)      idleQ <= 1'b1;
      else if (strobe.clrIdle) idleQ <= 1'b0;
      if (txQueue)             queuePend <= 1'b1;
      else if (txBusy)         queuePend <= 1'b0;
    end
  end

  assign txEmpty    = teQ;
  assign rxFull     = rfQ;
  assign rxIdle     = idleQ;
  assign txComplete = teQ & ~txBusy & ~queuePend;
  assign txIrq      = txComplete & txDoneIe;
  assign rxIrq      = rfQ & rxFullIe;
  assign errIrq     = idleQ & idleIe;

  a_r4_queue_drops_tc: assert property (@(posedge clk) disable iff (!rstN)
    txQueue |=> !txComplete);

  a_r9_idle_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setIdle |=> rxIdle);

endmodule

// File: rtl/uart_flag_unit.sv
`timescale 1ns/1ps
module uart_flag_unit
  import uart_flag_pkg::*;
#(
  parameter int CHAR_BITS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic statusRd,
  input  logic dataRd,
  input  logic dataWr,
  input  logic txDoneIe,
  input  logic rxFullIe,
  input  logic idleIe,
  input  logic txLoad,
  input  logic txQueue,
  input  logic txBusy,
  input  logic rxXfer,
  input  logic rxEn,
  input  logic bitTick,
  input  logic rxLine,
  input  logic nineBit,
  output logic txEmpty,
  output logic txComplete,
  output logic rxFull,
  output logic rxIdle,
  output logic txIrq,
  output logic rxIrq,
  output logic errIrq
);

  flagStrobes_t strobe;

  uart_flag_ctrl #(.CHAR_BITS(CHAR_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .statusRd (statusRd),
    .dataRd   (dataRd),
    .dataWr   (dataWr),
    .txLoad   (txLoad),
    .rxXfer   (rxXfer),
    .rxEn     (rxEn),
    .bitTick  (bitTick),
    .rxLine   (rxLine),
    .nineBit  (nineBit),
    .txEmpty  (txEmpty),
    .rxFull   (rxFull),
    .rxIdle   (rxIdle),
    .strobe   (strobe)
  );

  uart_flag_regs u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .txQueue    (txQueue),
    .txBusy     (txBusy),
    .txDoneIe   (txDoneIe),
    .rxFullIe   (rxFullIe),
    .idleIe     (idleIe),
    .txEmpty    (txEmpty),
    .txComplete (txComplete),
    .rxFull     (rxFull),
    .rxIdle     (rxIdle),
    .txIrq      (txIrq),
    .rxIrq      (rxIrq),
    .errIrq     (errIrq)
  );

  a_r3_te_fall_on_write: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEmpty) |-> $past(dataWr));

  a_r5_rf_fall_on_read: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxFull) |-> $past(dataRd));

  a_r2_load_sets_te: assert property (@(posedge clk) disable iff (!rstN)
    txLoad |=> txEmpty);

  a_r9_xfer_sets_rf: assert property (@(posedge clk) disable iff (!rstN)
    rxXfer |=> rxFull);

  a_r4_tc_needs_te: assert property (@(posedge clk) disable iff (!rstN)
    txComplete |-> (txEmpty && !txBusy));

  a_r10_no_idle_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> !$rose(rxIdle));

endmodule

// File: tb/uart_flag_unit_tb.sv
`timescale 1ns/1ps
module uart_flag_unit_tb;

  logic clk = 1'b0;
  logic rstN;
  logic statusRd, dataRd, dataWr;
  logic txDoneIe, rxFullIe, idleIe;
  logic txLoad, txQueue, txBusy;
  logic rxXfer, rxEn, bitTick, rxLine, nineBit;
  logic txEmpty, txComplete, rxFull, rxIdle, txIrq, rxIrq, errIrq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  uart_flag_unit u_dut (
    .clk(clk), .rstN(rstN), .statusRd(statusRd), .dataRd(dataRd), .dataWr(dataWr),
    .txDoneIe(txDoneIe), .rxFullIe(rxFullIe), .idleIe(idleIe),
    .txLoad(txLoad), .txQueue(txQueue), .txBusy(txBusy),
    .rxXfer(rxXfer), .rxEn(rxEn), .bitTick(bitTick), .rxLine(rxLine), .nineBit(nineBit),
    .txEmpty(txEmpty), .txComplete(txComplete), .rxFull(rxFull), .rxIdle(rxIdle),
    .txIrq(txIrq), .rxIrq(rxIrq), .errIrq(errIrq)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic statusRead();
    statusRd = 1'b1; cyc(); statusRd = 1'b0;
  endtask

  task automatic clearRx();
    statusRead();
    dataRd = 1'b1; cyc(); dataRd = 1'b0;
  endtask

  // Re-enable the receiver, optionally receive a character, send one low
  // sample, then n high samples.
  task automatic idleRun(input logic mode, input int n, input logic withChar);
    rxEn = 1'b0; cyc();
    nineBit = mode; rxEn = 1'b1;
    if (withChar) begin rxXfer = 1'b1; cyc(); rxXfer = 1'b0; end
    bitTick = 1'b1; rxLine = 1'b0; cyc();
    rxLine = 1'b1;
    repeat (n) cyc();
    bitTick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    {statusRd, dataRd, dataWr, txDoneIe, rxFullIe, idleIe} = '0;
    {txLoad, txQueue, txBusy, rxXfer, rxEn, bitTick, rxLine, nineBit} = '0;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();

    // R1: reset state
    chk(txEmpty, 1'b1, "R1 txEmpty");
    chk(txComplete, 1'b1, "R1 txComplete");
    chk(rxFull, 1'b0, "R1 rxFull");
    chk(rxIdle, 1'b0, "R1 rxIdle");
    chk(txIrq | rxIrq | errIrq, 1'b0, "R1 no irq");

    // R3: a write that was not armed is ignored
    dataWr = 1'b1; cyc(); dataWr = 1'b0;
    chk(txEmpty, 1'b1, "R3 unarmed write");
    // R3: an armed write clears the flag
    statusRead();
    dataWr = 1'b1; cyc(); dataWr = 1'b0;
    chk(txEmpty, 1'b0, "R3 armed write");
    chk(txComplete, 1'b0, "R4 tc follows te");
    // R3: a status read while the flag is clear does not arm
    statusRead();
    txLoad = 1'b1; cyc(); txLoad = 1'b0;
    chk(txEmpty, 1'b1, "R2 load sets te");
    dataWr = 1'b1; cyc(); dataWr = 1'b0;
    chk(txEmpty, 1'b1, "R3 read while clear no arm");

    // R9: load in the same cycle as the completing write
    statusRead();
    dataWr = 1'b1; txLoad = 1'b1; cyc(); dataWr = 1'b0; txLoad = 1'b0;
    chk(txEmpty, 1'b1, "R9 load beats write");
    dataWr = 1'b1; cyc(); dataWr = 1'b0;
    chk(txEmpty, 1'b1, "R3 arming consumed");

    // R4: sweep te and busy with nothing pending
    for (int t = 0; t < 2; t++) begin
      for (int b = 0; b < 2; b++) begin
        if (t == 0) begin
          statusRead(); dataWr = 1'b1; cyc(); dataWr = 1'b0;
        end else begin
          txLoad = 1'b1; cyc(); txLoad = 1'b0;
        end
        txBusy = logic'(b); #1;
        chk(txComplete, logic'(t == 1 && b == 0), "R4 tc decode");
        txBusy = 1'b0; cyc();
      end
    end
    // R4: a queued frame holds tc low until busy has come and gone
    txQueue = 1'b1; cyc(); txQueue = 1'b0;
    chk(txComplete, 1'b0, "R4 queued drops tc");
    cyc();
    chk(txComplete, 1'b0, "R4 latency before busy");
    txBusy = 1'b1; repeat (3) cyc();
    chk(txComplete, 1'b0, "R4 busy");
    txBusy = 1'b0; #1;
    chk(txComplete, 1'b1, "R4 tc back after busy");

    // R5: receive-full set and clear
    rxXfer = 1'b1; cyc(); rxXfer = 1'b0;
    chk(rxFull, 1'b1, "R5 xfer sets");
    dataRd = 1'b1; cyc(); dataRd = 1'b0;
    chk(rxFull, 1'b1, "R5 unarmed read");
    clearRx();
    chk(rxFull, 1'b0, "R5 armed read clears");
    // R9: character arrives with the completing read
    rxXfer = 1'b1; cyc(); rxXfer = 1'b0;
    statusRead();
    dataRd = 1'b1; rxXfer = 1'b1; cyc(); dataRd = 1'b0; rxXfer = 1'b0;
    chk(rxFull, 1'b1, "R9 xfer beats read");
    clearRx();
    chk(rxFull, 1'b0, "R5 clear after set-wins");

    // R6 / R8: idle threshold sweep in both character modes
    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n < 14; n++) begin
        idleRun(logic'(m), n, 1'b1);
        chk(rxIdle, logic'(n >= 10 + m), $sformatf("R6 mode=%0d n=%0d", m, n));
        clearRx();
        chk(rxIdle, 1'b0, "R8 idle cleared");
      end
    end

    // R6: a low sample restarts the count
    idleRun(1'b0, 5, 1'b1);
    bitTick = 1'b1; rxLine = 1'b0; cyc(); rxLine = 1'b1;
    repeat (9) cyc();
    chk(rxIdle, 1'b0, "R6 restart on low");
    cyc(); bitTick = 1'b0;
    chk(rxIdle, 1'b1, "R6 tenth after restart");
    // R7: after a clear, idle needs a fresh character
    clearRx();
    bitTick = 1'b1; rxLine = 1'b0; cyc(); rxLine = 1'b1;
    repeat (15) cyc(); bitTick = 1'b0;
    chk(rxIdle, 1'b0, "R7 no rearm after clear");
    // R7: after enable, idle needs a character
    idleRun(1'b0, 15, 1'b0);
    chk(rxIdle, 1'b0, "R7 no char after enable");

    // R10: disabling drops the qualification
    idleRun(1'b0, 6, 1'b1);
    rxEn = 1'b0; cyc(); rxEn = 1'b1;
    bitTick = 1'b1; rxLine = 1'b1; repeat (12) cyc(); bitTick = 1'b0;
    chk(rxIdle, 1'b0, "R10 qualification dropped");
    // R10: disabling zeroes the count
    idleRun(1'b0, 6, 1'b1);
    rxEn = 1'b0; cyc(); rxEn = 1'b1;
    rxXfer = 1'b1; cyc(); rxXfer = 1'b0;
    bitTick = 1'b1; rxLine = 1'b1; repeat (4) cyc(); bitTick = 1'b0;
    chk(rxIdle, 1'b0, "R10 count zeroed");
    bitTick = 1'b1; repeat (6) cyc(); bitTick = 1'b0;
    chk(rxIdle, 1'b1, "R10 full run after re-enable");

    // R11: enable sweep with all flags set, then with rx flags clear
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) clearRx();
      for (int e = 0; e < 8; e++) begin
        {txDoneIe, rxFullIe, idleIe} = 3'(e); #1;
        chk(txIrq,  logic'(e[2]), "R11 txIrq");
        chk(rxIrq,  logic'(e[1] && pass == 0), "R11 rxIrq");
        chk(errIrq, logic'(e[0] && pass == 0), "R11 errIrq");
      end
      {txDoneIe, rxFullIe, idleIe} = '0;
    end

    cyc();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule